// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block sequences the clock and power state of a small processor core. It holds the current operating mode and decides when to leave it. The modes are full-speed run, slow run, doze, sleep, deep sleep with the PLL stopped, power-down, and a PLL-settling wait. Software enters a mode through a one-cycle request. Wake causes bring the core back to full-speed run after fixed, known latencies. The wake causes are a level-sensitive asynchronous wake line, a synchronous interrupt-pending line, timer events, and a hard-reset input.

A timer event sets a sticky expiry flag, which also drives an output pin. While the flag is set it counts as a pending wake. Software clears it before asking for any low-power mode. Leaving deep sleep starts a settling counter. The counter is advanced by a PLL reference-clock strobe and is longer when the PLL runs in 1:1 mode. Power-down is left only through the hard reset that external logic raises in response to the expiry pin. The block also reports the PLL enable, the slow-clock select and the divisor that the slow clock uses.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset the block is in full-speed run with all outputs at their idle values. This means mode 0, PLL enabled, slow select low, divisor 1, flag and pin clear, settling count 0.
- R2: The asynchronous wake line passes through a two-stage synchronizer. While it is held high in slow run, doze or sleep, the mode becomes full-speed run at the third rising edge after it rises, and not earlier.
- R3: A held interrupt-pending request moves slow run or doze to full-speed run at the second rising edge after it rises. It has no effect in sleep.
- R4: A timer event sets the expiry flag and pin at the next edge. The flag then holds until the clear input or a frequency fall-back clears it, and a set wins over a clear. While set, the flag moves slow run, doze or sleep to full-speed run at the following edge.
- R5: A mode request (enter strobe with code 0 run, 1 slow run, 2 doze, 3 sleep, 4 deep sleep, 5 power-down) takes effect at the next edge. It is honoured only from full-speed run or slow run, and only while no wake cause is pending (hard reset, synchronized wake, expiry flag, registered interrupt). Codes 6 and 7 are ignored.
- R6: With the frequency-toggle enable set, the slow-to-fast step in slow run requires a pending interrupt and a clear low-power request bit. In full-speed run, the absence of that condition drops the mode to slow run and clears the expiry flag.
- R7: In deep sleep, the synchronized wake or the expiry flag moves the mode to settling (code 6). At that edge the settling count loads 999 when 1:1 mode is selected and 499 otherwise.
- R8: The settling count decreases by one only on edges where the reference strobe is high. The mode becomes full-speed run at the edge after the count reaches zero. With the strobe always high this is 500 edges after settling starts, or 1000 in 1:1 mode.
- R9: Power-down is left only by hard reset. The asynchronous wake and the expiry flag leave it unchanged, though a timer event still sets the flag and pin.
- R10: Hard reset has the highest priority. It sets the expiry flag and overrides a mode request in the same cycle. It moves deep sleep, power-down and settling to settling, reloading the count, and any other mode to full-speed run.
- R11: The PLL enable is low only in deep sleep and power-down. The slow select is high in every mode except full-speed run. The divisor is 1 in full-speed run and 2^(code+1) otherwise, for a 3-bit divide code: 0 gives 2, 7 gives 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_rst_i | input | 1 | Hard-reset request, sampled on the clock |
| async_wake_i | input | 1 | Level-sensitive asynchronous wake |
| irq_pend_i | input | 1 | Synchronous interrupt pending |
| tmr_evt_i | input | 1 | Enabled timer event |
| tmr_clr_i | input | 1 | Software clear of the expiry flag |
| lp_req_i | input | 1 | Software low-power request bit |
| toggle_en_i | input | 1 | Frequency-toggle enable |
| enter_i | input | 1 | Mode request strobe |
| mode_req_i | input | 3 | Requested mode code |
| pll_1to1_i | input | 1 | PLL in 1:1 mode, selects the long settling wait |
| ref_tick_i | input | 1 | PLL reference-clock enable strobe |
| div_code_i | input | DIV_W | Slow-clock divide code |
| mode_o | output | 3 | Current mode code |
| low_freq_o | output | 1 | Slow clock selected |
| divisor_o | output | 2**DIV_W+1 | Current clock divisor |
| pll_en_o | output | 1 | PLL enable |
| settle_cnt_o | output | CNT_W | PLL settling count |
| tmr_flag_o | output | 1 | Sticky timer-expiry flag |
| tmr_pin_o | output | 1 | Timer-expiry pin for external reset logic |

## Verification
A wrong mode register shows at once on the mode code, PLL enable and divisor. A wake path that is one stage short or long shows as a mode change one edge early or late, so each wake latency is checked at both the edge before the expected one and at the expected edge. A bad settling counter shows at the start of settling as a wrong load value, and at the end as a release that comes one strobe off the 500 or 1000 boundary. A flag that fails to stick or clear shows on the pin, and through entries being refused or wakes that fire on their own.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_HIGH   = 3'd0,
    M_LOW    = 3'd1,
    M_DOZE   = 3'd2,
    M_SLEEP  = 3'd3,
    M_DEEP   = 3'd4,
    M_DOWN   = 3'd5,
    M_SETTLE = 3'd6
  } lpm_mode_e;
endpackage

// File: rtl/lpm_sync_stage.sv
module lpm_sync_stage #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = d_i;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned SHORT_LOAD = 499,
  parameter int unsigned LONG_LOAD  = 999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             long_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero_o = (cnt_q == '0);
  assign cnt_en = load_i | (tick_i & ~zero_o);

  always_comb begin
    if (load_i) cnt_d = long_i ? CNT_W'(LONG_LOAD) : CNT_W'(SHORT_LOAD);
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst_i,
  input  logic              async_wk_i,
  input  logic              irq_q_i,
  input  logic              tmr_evt_i,
  input  logic              tmr_clr_i,
  input  logic              lp_req_i,
  input  logic              toggle_en_i,
  input  logic              enter_i,
  input  logic [MODE_W-1:0] mode_req_i,
  input  logic              settle_zero_i,
  output lpm_mode_e         mode_o,
  output logic              settle_load_o,
  output logic              tmr_flag_o
);
  lpm_mode_e mode_q, mode_d;
  logic      flag_q, flag_d;
  logic      fall_back;
  logic      pending;
  logic      req_ok;
  logic      fast_ok;

  assign pending = hard_rst_i | async_wk_i | flag_q | irq_q_i;
  assign req_ok  = enter_i & ~pending & (mode_req_i <= MODE_W'(5));
  assign fast_ok = irq_q_i & ~(toggle_en_i & lp_req_i);

  always_comb begin
    mode_d        = mode_q;
    settle_load_o = 1'b0;
    fall_back     = 1'b0;
    if (hard_rst_i) begin
      if (mode_q inside {M_DEEP, M_DOWN, M_SETTLE}) begin
        mode_d        = M_SETTLE;
        settle_load_o = 1'b1;
      end else begin
        mode_d = M_HIGH;
      end
    end else begin
      unique case (mode_q)
        M_HIGH: begin
          if (req_ok) mode_d = lpm_mode_e'(mode_req_i);
          else if (toggle_en_i && !(irq_q_i && !lp_req_i)) begin
            mode_d    = M_LOW;
            fall_back = 1'b1;
          end
        end
        M_LOW: begin
          if (async_wk_i || flag_q) mode_d = M_HIGH;
          else if (fast_ok)         mode_d = M_HIGH;
          else if (req_ok)          mode_d = lpm_mode_e'(mode_req_i);
        end
        M_DOZE:  if (async_wk_i || flag_q || irq_q_i) mode_d = M_HIGH;
        M_SLEEP: if (async_wk_i || flag_q) mode_d = M_HIGH;
        M_DEEP: begin
          if (async_wk_i || flag_q) begin
            mode_d        = M_SETTLE;
            settle_load_o = 1'b1;
          end
        end
        M_SETTLE: if (settle_zero_i) mode_d = M_HIGH;
        default: mode_d = mode_q;
      endcase
    end
  end

  always_comb begin
    if (tmr_evt_i || hard_rst_i)    flag_d = 1'b1;
    else if (tmr_clr_i || fall_back) flag_d = 1'b0;
    else                             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_HIGH;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o     = mode_q;
  assign tmr_flag_o = flag_q;
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned DIV_W        = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SETTLE_SHORT = 499,
  parameter int unsigned SETTLE_LONG  = 999,
  localparam int unsigned CNT_W       = $clog2(SETTLE_LONG + 1),
  localparam int unsigned DIVISOR_W   = (1 << DIV_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hard_rst_i,
  input  logic                 async_wake_i,
  input  logic                 irq_pend_i,
  input  logic                 tmr_evt_i,
  input  logic                 tmr_clr_i,
  input  logic                 lp_req_i,
  input  logic                 toggle_en_i,
  input  logic                 enter_i,
  input  logic [2:0]           mode_req_i,
  input  logic                 pll_1to1_i,
  input  logic                 ref_tick_i,
  input  logic [DIV_W-1:0]     div_code_i,
  output logic [2:0]           mode_o,
  output logic                 low_freq_o,
  output logic [DIVISOR_W-1:0] divisor_o,
  output logic                 pll_en_o,
  output logic [CNT_W-1:0]     settle_cnt_o,
  output logic                 tmr_flag_o,
  output logic                 tmr_pin_o
);
  logic      async_s;
  logic      irq_q;
  logic      settle_load;
  logic      settle_zero;
  lpm_mode_e mode;
  logic [DIV_W:0] shamt;

  lpm_sync_stage #(.STAGES(SYNC_STAGES)) u_async_sync (
    .clk(clk), .rst_n(rst_n), .d_i(async_wake_i), .q_o(async_s)
  );

  lpm_sync_stage #(.STAGES(1)) u_irq_reg (
    .clk(clk), .rst_n(rst_n), .d_i(irq_pend_i), .q_o(irq_q)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hard_rst_i(hard_rst_i), .async_wk_i(async_s),
    .irq_q_i(irq_q), .tmr_evt_i(tmr_evt_i), .tmr_clr_i(tmr_clr_i),
    .lp_req_i(lp_req_i), .toggle_en_i(toggle_en_i), .enter_i(enter_i),
    .mode_req_i(mode_req_i), .settle_zero_i(settle_zero), .mode_o(mode),
    .settle_load_o(settle_load), .tmr_flag_o(tmr_flag_o)
  );

  lpm_settle_cnt #(
    .CNT_W(CNT_W), .SHORT_LOAD(SETTLE_SHORT), .LONG_LOAD(SETTLE_LONG)
  ) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(settle_load), .long_i(pll_1to1_i),
    .tick_i(ref_tick_i), .cnt_o(settle_cnt_o), .zero_o(settle_zero)
  );

  assign shamt = {1'b0, div_code_i} + (DIV_W+1)'(1);

  always_comb begin
    if (mode == M_HIGH) divisor_o = DIVISOR_W'(1);
    else                divisor_o = DIVISOR_W'(1) << shamt;
  end

  assign mode_o     = mode;
  assign low_freq_o = (mode != M_HIGH);
  assign pll_en_o   = !(mode inside {M_DEEP, M_DOWN});
  assign tmr_pin_o  = tmr_flag_o;
endmodule

// File: rtl/lpm_wake_chk.sv
module lpm_wake_chk
  import lpm_pkg::*;
#(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned CNT_MAX = 999
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hard_rst_i,
  input logic             ref_tick_i,
  input logic             tmr_evt_i,
  input logic             tmr_clr_i,
  input logic             toggle_en_i,
  input logic [2:0]       mode_o,
  input logic             tmr_flag_o,
  input logic [CNT_W-1:0] settle_cnt_o
);
  AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt_i |=> tmr_flag_o); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag_o && !tmr_clr_i && !toggle_en_i) |=> tmr_flag_o); // R4

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    settle_cnt_o <= CNT_W'(CNT_MAX)); // R7

  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_SETTLE && !ref_tick_i && !hard_rst_i) |=> $stable(settle_cnt_o)); // R8

  AST_SETTLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == M_SETTLE && mode_o == M_HIGH) |-> $past(settle_cnt_o) == '0); // R8

  AST_DOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == M_DOWN && mode_o != M_DOWN) |-> $past(hard_rst_i)); // R9

  AST_HARD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_i |=> tmr_flag_o); // R10
endmodule

bind lpm_wake_ctrl lpm_wake_chk #(.CNT_W(CNT_W), .CNT_MAX(SETTLE_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .hard_rst_i(hard_rst_i), .ref_tick_i(ref_tick_i),
  .tmr_evt_i(tmr_evt_i), .tmr_clr_i(tmr_clr_i), .toggle_en_i(toggle_en_i),
  .mode_o(mode_o), .tmr_flag_o(tmr_flag_o), .settle_cnt_o(settle_cnt_o)
);

// File: tb/lpm_wake_ctrl_tb_top.sv
module lpm_wake_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hard_rst_i, async_wake_i, irq_pend_i, tmr_evt_i, tmr_clr_i;
  logic       lp_req_i, toggle_en_i, enter_i, pll_1to1_i, ref_tick_i;
  logic [2:0] mode_req_i, div_code_i, mode_o;
  logic       low_freq_o, pll_en_o, tmr_flag_o, tmr_pin_o;
  logic [8:0] divisor_o;
  logic [9:0] settle_cnt_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  lpm_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hard_rst_i(hard_rst_i), .async_wake_i(async_wake_i),
    .irq_pend_i(irq_pend_i), .tmr_evt_i(tmr_evt_i), .tmr_clr_i(tmr_clr_i),
    .lp_req_i(lp_req_i), .toggle_en_i(toggle_en_i), .enter_i(enter_i),
    .mode_req_i(mode_req_i), .pll_1to1_i(pll_1to1_i), .ref_tick_i(ref_tick_i),
    .div_code_i(div_code_i), .mode_o(mode_o), .low_freq_o(low_freq_o),
    .divisor_o(divisor_o), .pll_en_o(pll_en_o), .settle_cnt_o(settle_cnt_o),
    .tmr_flag_o(tmr_flag_o), .tmr_pin_o(tmr_pin_o)
  );

  // Vector fields: [12:10] entered mode, [9:7] stimulus, [6:3] edges, [2:0] mode expected
  // Stimulus: 1 async wake, 2 interrupt pending, 3 timer event, 4 hard reset
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {3'd1, 3'd1, 4'd3, 3'd0},  // R2 slow run
    {3'd2, 3'd1, 4'd3, 3'd0},  // R2 doze
    {3'd3, 3'd1, 4'd3, 3'd0},  // R2 sleep
    {3'd1, 3'd2, 4'd2, 3'd0},  // R3 slow run
    {3'd2, 3'd2, 4'd2, 3'd0},  // R3 doze
    {3'd3, 3'd3, 4'd2, 3'd0},  // R4 sleep
    {3'd1, 3'd3, 4'd2, 3'd0},  // R4 slow run
    {3'd4, 3'd1, 4'd3, 3'd6},  // R7 deep via wake
    {3'd4, 3'd3, 4'd2, 3'd6},  // R7 deep via timer
    {3'd5, 3'd4, 4'd1, 3'd6},  // R10 power-down
    {3'd3, 3'd4, 4'd1, 3'd0}   // R10 sleep
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hard_rst_i = 0; async_wake_i = 0; irq_pend_i = 0; tmr_evt_i = 0; tmr_clr_i = 0;
    lp_req_i = 0; toggle_en_i = 0; enter_i = 0; pll_1to1_i = 0; ref_tick_i = 1;
    mode_req_i = 0; div_code_i = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic go_mode(input logic [2:0] m);
    enter_i = 1'b1;
    mode_req_i = m;
    step(1);
    enter_i = 1'b0;
  endtask

  task automatic set_stim(input logic [2:0] s, input logic v);
    case (s)
      3'd1: async_wake_i = v;
      3'd2: irq_pend_i = v;
      3'd3: tmr_evt_i = v;
      3'd4: hard_rst_i = v;
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "mode", mode_o, 0);
    chk("R1", "pll_en", pll_en_o, 1);
    chk("R1", "low_freq", low_freq_o, 0);
    chk("R1", "divisor", divisor_o, 1);
    chk("R1", "flag", tmr_flag_o, 0);
    chk("R1", "pin", tmr_pin_o, 0);
    chk("R1", "settle_cnt", settle_cnt_o, 0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] ent, stim, exp_m;
      int cyc;
      ent = VEC[v][12:10]; stim = VEC[v][9:7]; cyc = int'(VEC[v][6:3]); exp_m = VEC[v][2:0];
      do_reset();
      go_mode(ent);
      chk("R5", "entry", mode_o, ent);
      set_stim(stim, 1'b1);
      step(cyc - 1);
      chk("R2/R3/R4 latency", "mode early", mode_o, ent);
      step(1);
      chk("R2/R3/R4/R7/R10 vector", "mode", mode_o, exp_m);
      set_stim(stim, 1'b0);
    end

    // R7 R8 short settle with a strobe every cycle
    do_reset();
    go_mode(3'd4);
    chk("R11", "pll_en deep", pll_en_o, 0);
    async_wake_i = 1; step(3); async_wake_i = 0;
    chk("R7", "settle mode", mode_o, 6);
    chk("R7", "short load", settle_cnt_o, 499);
    step(499);
    chk("R8", "count at zero", settle_cnt_o, 0);
    chk("R8", "still settling", mode_o, 6);
    step(1);
    chk("R8", "released", mode_o, 0);

    // R7 R8 long settle with a paused strobe
    do_reset();
    pll_1to1_i = 1; ref_tick_i = 0;
    go_mode(3'd4);
    async_wake_i = 1; step(3); async_wake_i = 0;
    chk("R7", "long load", settle_cnt_o, 999);
    step(5);
    chk("R8", "no strobe hold", settle_cnt_o, 999);
    ref_tick_i = 1;
    step(999);
    chk("R8", "long still settling", mode_o, 6);
    step(1);
    chk("R8", "long released", mode_o, 0);

    // R9 power-down ignores wakes; R10 hard reset leaves it
    do_reset();
    go_mode(3'd5);
    chk("R11", "pll_en down", pll_en_o, 0);
    tmr_evt_i = 1; step(1); tmr_evt_i = 0;
    chk("R9", "flag in down", tmr_flag_o, 1);
    chk("R4", "pin in down", tmr_pin_o, 1);
    async_wake_i = 1; step(6); async_wake_i = 0;
    chk("R9", "stays down", mode_o, 5);
    hard_rst_i = 1; step(1); hard_rst_i = 0;
    chk("R10", "down exit", mode_o, 6);

    // R10 hard reset sets flag; R5 entry refused while flag set; R4 clear
    do_reset();
    hard_rst_i = 1; step(1); hard_rst_i = 0;
    chk("R10", "flag set", tmr_flag_o, 1);
    chk("R10", "run kept", mode_o, 0);
    go_mode(3'd1);
    chk("R5", "refused with flag", mode_o, 0);
    chk("R4", "flag sticky", tmr_flag_o, 1);
    tmr_clr_i = 1; step(1); tmr_clr_i = 0;
    chk("R4", "flag cleared", tmr_flag_o, 0);
    go_mode(3'd1);
    chk("R5", "slow accepted", mode_o, 1);
    div_code_i = 3'd7; #1;
    chk("R11", "divisor code 7", divisor_o, 256);
    chk("R11", "low_freq", low_freq_o, 1);
    div_code_i = 3'd0; #1;
    chk("R11", "divisor code 0", divisor_o, 2);
    @(negedge clk);
    go_mode(3'd7);
    chk("R5", "invalid code ignored", mode_o, 1);
    go_mode(3'd0);
    chk("R5", "back to run", mode_o, 0);
    chk("R11", "run divisor", divisor_o, 1);

    // R10 priority over a same-cycle request
    hard_rst_i = 1; go_mode(3'd4); hard_rst_i = 0;
    chk("R10", "request overridden", mode_o, 0);

    // R3 interrupt ignored in sleep
    do_reset();
    go_mode(3'd3);
    irq_pend_i = 1; step(5); irq_pend_i = 0;
    chk("R3", "sleep ignores irq", mode_o, 3);

    // R6 frequency toggle
    do_reset();
    toggle_en_i = 1; lp_req_i = 1;
    step(1);
    chk("R6", "fall to slow", mode_o, 1);
    irq_pend_i = 1; step(4);
    chk("R6", "lp_req blocks rise", mode_o, 1);
    lp_req_i = 0; step(1);
    chk("R6", "rise to run", mode_o, 0);
    tmr_evt_i = 1; step(1); tmr_evt_i = 0; irq_pend_i = 0;
    chk("R6", "flag raised", tmr_flag_o, 1);
    step(2);
    chk("R6", "fall back", mode_o, 1);
    chk("R6", "flag cleared on fall", tmr_flag_o, 0);

    finish_run();
  end
endmodule